// File: doc/BRIEF.md
# Load-Use Stall Unit

This block sits beside the decode stage of a five-stage in-order pipeline. It spots the one dependency that operand bypassing cannot cover: the instruction being decoded reads a register that a memory load, now one stage ahead in execute, has not yet fetched from memory. When that happens the block holds the program counter and the fetch/decode register for one cycle. In the same cycle it writes an all-zero control word into the execute register, so a do-nothing slot travels down the pipe. One cycle later the loaded value can reach the consumer over the normal bypass path from the write-back register.

The block carries its own small model of the program counter, the fetch/decode register and the control half of the decode/execute register, so that it can be exercised on its own. The surrounding instruction memory drives the fields of the fetched instruction from `pc_o`. Bit `MRD_BIT` (default 0) of a control word marks a memory read. The other control bits are carried through without being interpreted.

Top module: `load_use_stall_unit`

## Requirements
- R1: While `rst_n` is low, `pc_o` is 0, `ex_ctl_o` is all zeros, `bubble_o` is 0, and `pc_write_o` and `ifid_write_o` are both 1.
- R2: When `ex_ctl_o[0]` (memory read) is 1 and `ex_rt_o` equals `dec_rs_o`, the stall is raised in that same cycle: `bubble_o` is 1 and `pc_write_o` and `ifid_write_o` are 0.
- R3: A load whose `ex_rt_o` equals `dec_rt_o`, the second source, also raises the stall.
- R4: An instruction in execute whose memory-read bit is 0 never causes a stall, even when its `ex_rt_o` matches a decode source.
- R5: A load whose destination matches neither decode source causes no stall.
- R6: In the cycle after a stall, `ex_ctl_o` is all zeros. Without a stall, `ex_ctl_o` takes the control word that was held in decode.
- R7: During a stall, `pc_o`, `dec_rs_o` and `dec_rt_o` hold their values at the next edge, so the same instruction is decoded again and the same address is fetched again.
- R8: A stall lasts exactly one cycle. The consumer then moves into execute with its own control word.
- R9: Register number 0 is compared like any other: a load to register 0 followed by a reader of register 0 stalls.
- R10: Without a stall, `pc_o` rises by 1 at each edge, and the fetched fields appear on `dec_rs_o`/`dec_rt_o` after one edge.
- R11: A consumer placed two instructions after the load it depends on causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_rs | input | REG_W | First source register of the instruction at `pc_o` |
| fetch_rt | input | REG_W | Second source register; for a load, the destination |
| fetch_ctl | input | CTL_W | Decoded control word of the fetched instruction |
| pc_o | output | PC_W | Program counter |
| dec_rs_o | output | REG_W | First source held in the fetch/decode register |
| dec_rt_o | output | REG_W | Second source held in the fetch/decode register |
| ex_ctl_o | output | CTL_W | Control word held in the decode/execute register |
| ex_rt_o | output | REG_W | rt field held in the decode/execute register |
| pc_write_o | output | 1 | Program counter update enable |
| ifid_write_o | output | 1 | Fetch/decode register update enable |
| bubble_o | output | 1 | Forces a zero control word into decode/execute |

## Verification
Two functions can land in the same cycle: releasing a stall and detecting a fresh load-use pair. The bench sets this up with a load that itself reads the result of the load just before it, followed at once by a reader of the second load. The first stall frees the second load into execute in the very cycle its own consumer reaches decode. The run is judged correct only if it shows two separate single-cycle bubbles, with the same program-counter value held across each, and if every bubble cycle leaves a zero control word in execute on the next edge.

// File: rtl/lus_pkg.sv
package lus_pkg;
   // Default geometry shared by the unit, its checker and its bench
   localparam int unsigned LUS_REG_W   = 5;
   localparam int unsigned LUS_CTL_W   = 6;
   localparam int unsigned LUS_PC_W    = 8;
   localparam int unsigned LUS_MRD_BIT = 0;

   // Flow state of the front end for one cycle
   typedef enum logic {
      FLOW_RUN  = 1'b0,
      FLOW_HOLD = 1'b1
   } flow_e;
endpackage

// File: rtl/lus_match.sv
module lus_match #(
   parameter int unsigned REG_W = 5,
   parameter int unsigned NSRC  = 2
) (
   input  logic                       ld_valid,
   input  logic [REG_W-1:0]           ld_dst,
   input  logic [NSRC-1:0][REG_W-1:0] srcs,
   output logic                       hit
);
   logic [NSRC-1:0] eq;

   // One comparator per decode source; register 0 gets no exemption
   for (genvar g = 0; g < NSRC; g++) begin : g_cmp
      assign eq[g] = (srcs[g] == ld_dst);
   end

   assign hit = ld_valid & (|eq);
endmodule

// File: rtl/lus_stage_reg.sv
module lus_stage_reg #(
   parameter int unsigned W       = 8,
   parameter bit          HAS_ZAP = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic         zap,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (HAS_ZAP) begin : g_zap
      // Control half: a bubble overrides the incoming word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   q <= '0;
         else if (zap) q <= '0;
         else if (en)  q <= d;
      end
   end else begin : g_plain
      logic unused_zap;
      assign unused_zap = zap;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q <= '0;
         else if (en) q <= d;
      end
   end
endmodule

// File: rtl/lus_pc_reg.sv
module lus_pc_reg #(
   parameter int unsigned PC_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   output logic [PC_W-1:0] pc
);
   localparam logic [PC_W-1:0] STEP = PC_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pc <= '0;
      else if (en) pc <= pc + STEP;
   end
endmodule

// File: rtl/load_use_stall_unit.sv
module load_use_stall_unit
   import lus_pkg::*;
#(
   parameter int unsigned REG_W   = LUS_REG_W,
   parameter int unsigned CTL_W   = LUS_CTL_W,
   parameter int unsigned PC_W    = LUS_PC_W,
   parameter int unsigned MRD_BIT = LUS_MRD_BIT
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] fetch_rs,
   input  logic [REG_W-1:0] fetch_rt,
   input  logic [CTL_W-1:0] fetch_ctl,
   output logic [PC_W-1:0]  pc_o,
   output logic [REG_W-1:0] dec_rs_o,
   output logic [REG_W-1:0] dec_rt_o,
   output logic [CTL_W-1:0] ex_ctl_o,
   output logic [REG_W-1:0] ex_rt_o,
   output logic             pc_write_o,
   output logic             ifid_write_o,
   output logic             bubble_o
);
   localparam int unsigned NSRC   = 2;
   localparam int unsigned IFID_W = 2 * REG_W + CTL_W;

   // Elaboration-time parameter checks
   if (REG_W < 1) begin : g_bad_reg
      $error("REG_W must be at least 1");
   end
   if (PC_W < 2) begin : g_bad_pc
      $error("PC_W must be at least 2");
   end
   if (MRD_BIT >= CTL_W) begin : g_bad_mrd
      $error("MRD_BIT must index into the control word");
   end

   logic [IFID_W-1:0]            ifid_d, ifid_q;
   logic [CTL_W-1:0]             dec_ctl;
   logic [NSRC-1:0][REG_W-1:0]   dec_srcs;
   logic                         load_use;
   flow_e                        flow;

   // Fetch/decode register: both sources plus the decoded control word
   assign ifid_d = {fetch_rs, fetch_rt, fetch_ctl};
   assign {dec_rs_o, dec_rt_o, dec_ctl} = ifid_q;

   lus_stage_reg #(.W(IFID_W), .HAS_ZAP(1'b0)) u_ifid (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (ifid_write_o),
      .zap  (1'b0),
      .d    (ifid_d),
      .q    (ifid_q)
   );

   // Load-use detection against the load sitting in execute
   assign dec_srcs[0] = dec_rs_o;
   assign dec_srcs[1] = dec_rt_o;

   lus_match #(.REG_W(REG_W), .NSRC(NSRC)) u_match (
      .ld_valid(ex_ctl_o[MRD_BIT]),
      .ld_dst  (ex_rt_o),
      .srcs    (dec_srcs),
      .hit     (load_use)
   );

   assign flow         = load_use ? FLOW_HOLD : FLOW_RUN;
   assign bubble_o     = (flow == FLOW_HOLD);
   assign pc_write_o   = (flow == FLOW_RUN);
   assign ifid_write_o = (flow == FLOW_RUN);

   // Program counter
   lus_pc_reg #(.PC_W(PC_W)) u_pc (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (pc_write_o),
      .pc   (pc_o)
   );

   // Decode/execute control word, zeroed when a bubble is injected
   lus_stage_reg #(.W(CTL_W), .HAS_ZAP(1'b1)) u_idex_ctl (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (1'b1),
      .zap  (bubble_o),
      .d    (dec_ctl),
      .q    (ex_ctl_o)
   );

   // Decode/execute rt field always advances
   lus_stage_reg #(.W(REG_W), .HAS_ZAP(1'b0)) u_idex_rt (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (1'b1),
      .zap  (1'b0),
      .d    (dec_rt_o),
      .q    (ex_rt_o)
   );
endmodule

// File: rtl/lus_chk.sv
module lus_chk #(
   parameter int unsigned REG_W   = 5,
   parameter int unsigned CTL_W   = 6,
   parameter int unsigned PC_W    = 8,
   parameter int unsigned MRD_BIT = 0
) (
   input logic             clk,
   input logic             rst_n,
   input logic [PC_W-1:0]  pc_o,
   input logic [REG_W-1:0] dec_rs_o,
   input logic [REG_W-1:0] dec_rt_o,
   input logic [CTL_W-1:0] ex_ctl_o,
   input logic             pc_write_o,
   input logic             ifid_write_o,
   input logic             bubble_o
);
   // R8
   one_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_o |=> !bubble_o);

   // R6
   bubble_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_o |=> (ex_ctl_o == '0));

   // R7
   pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_write_o |=> $stable(pc_o));

   // R7
   dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ifid_write_o |=> ($stable(dec_rs_o) && $stable(dec_rt_o)));

   // R10
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pc_write_o |=> (pc_o == $past(pc_o) + PC_W'(1)));

   // R4
   no_load_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_ctl_o[MRD_BIT] |-> !bubble_o);
endmodule

bind load_use_stall_unit lus_chk #(
   .REG_W  (REG_W),
   .CTL_W  (CTL_W),
   .PC_W   (PC_W),
   .MRD_BIT(MRD_BIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pc_o        (pc_o),
   .dec_rs_o    (dec_rs_o),
   .dec_rt_o    (dec_rt_o),
   .ex_ctl_o    (ex_ctl_o),
   .pc_write_o  (pc_write_o),
   .ifid_write_o(ifid_write_o),
   .bubble_o    (bubble_o)
);

// File: tb/sim_load_use_stall_unit.sv
module sim_load_use_stall_unit;
   localparam int CLK_T = 10;
   localparam int REG_W = 5;
   localparam int CTL_W = 6;
   localparam int PC_W  = 8;
   localparam int PLEN  = 32;
   localparam logic [CTL_W-1:0] C_NOP = 6'b000000;
   localparam logic [CTL_W-1:0] C_ALU = 6'b000010;
   localparam logic [CTL_W-1:0] C_LD  = 6'b000011;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_T/2) clk = ~clk;

   logic [REG_W-1:0] fetch_rs, fetch_rt, dec_rs_o, dec_rt_o, ex_rt_o;
   logic [CTL_W-1:0] fetch_ctl, ex_ctl_o;
   logic [PC_W-1:0]  pc_o;
   logic pc_write_o, ifid_write_o, bubble_o;

   load_use_stall_unit u0 (
      .clk(clk), .rst_n(rst_n),
      .fetch_rs(fetch_rs), .fetch_rt(fetch_rt), .fetch_ctl(fetch_ctl),
      .pc_o(pc_o), .dec_rs_o(dec_rs_o), .dec_rt_o(dec_rt_o),
      .ex_ctl_o(ex_ctl_o), .ex_rt_o(ex_rt_o),
      .pc_write_o(pc_write_o), .ifid_write_o(ifid_write_o), .bubble_o(bubble_o)
   );

   // Program memory
   logic [REG_W-1:0] p_rs [PLEN];
   logic [REG_W-1:0] p_rt [PLEN];
   logic [CTL_W-1:0] p_ctl[PLEN];

   function automatic void put(int a, int rs, int rt, logic [CTL_W-1:0] c);
      p_rs[a] = REG_W'(rs); p_rt[a] = REG_W'(rt); p_ctl[a] = c;
   endfunction

   always_comb begin
      if (int'(pc_o) < PLEN) begin
         fetch_rs = p_rs[pc_o[4:0]]; fetch_rt = p_rt[pc_o[4:0]]; fetch_ctl = p_ctl[pc_o[4:0]];
      end else begin
         fetch_rs = '0; fetch_rt = '0; fetch_ctl = C_NOP;
      end
   end

   // Behavioural reference state
   int m_pc, m_dpc, m_rs, m_rt, m_ctl, m_ex_ctl, m_ex_rt;
   int stalls[PLEN];
   int checks = 0, fails = 0;
   bit run = 0, done = 0;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_pc = 0; m_dpc = -1; m_rs = 0; m_rt = 0; m_ctl = 0;
         m_ex_ctl = 0; m_ex_rt = 0;
      end else begin
         bit haz;
         haz = (m_ex_ctl % 2 == 1) && (m_ex_rt == m_rs || m_ex_rt == m_rt);
         m_ex_ctl = haz ? 0 : m_ctl;
         m_ex_rt  = m_rt;
         if (!haz) begin
            if (m_pc < PLEN) begin
               m_rs = p_rs[m_pc]; m_rt = p_rt[m_pc]; m_ctl = p_ctl[m_pc];
            end else begin
               m_rs = 0; m_rt = 0; m_ctl = 0;
            end
            m_dpc = m_pc;
            m_pc++;
         end
      end
   end

   // Every-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n && run) begin
         bit haz;
         haz = (m_ex_ctl % 2 == 1) && (m_ex_rt == m_rs || m_ex_rt == m_rt);
         chk("R10 pc", int'(pc_o), m_pc);
         chk("R7 dec_rs", int'(dec_rs_o), m_rs);
         chk("R7 dec_rt", int'(dec_rt_o), m_rt);
         chk("R6 ex_ctl", int'(ex_ctl_o), m_ex_ctl);
         chk("R2 bubble", int'(bubble_o), int'(haz));
         chk("R2 pc_write", int'(pc_write_o), int'(!haz));
         chk("R7 ifid_write", int'(ifid_write_o), int'(!haz));
         if (bubble_o && m_dpc >= 0 && m_dpc < PLEN) stalls[m_dpc]++;
      end
   end

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < PLEN; i++) begin put(i, 0, 0, C_NOP); stalls[i] = 0; end
      put(1, 2, 1, C_LD);   put(2, 1, 3, C_ALU);    // rs match
      put(5, 2, 4, C_LD);   put(6, 7, 4, C_ALU);    // rt match
      put(9, 2, 8, C_LD);   put(10, 9, 10, C_ALU);  // independent
      put(12, 2, 11, C_LD); put(14, 11, 6, C_ALU);  // two slots later
      put(16, 2, 12, C_ALU); put(17, 12, 6, C_ALU); // non-load writer
      put(18, 3, 3, C_NOP);
      put(19, 2, 0, C_LD);  put(20, 0, 5, C_ALU);   // register 0
      put(21, 3, 3, C_NOP);
      put(22, 3, 13, C_LD); put(23, 13, 14, C_LD); put(24, 14, 6, C_ALU);
      for (int i = 25; i < PLEN; i++) put(i, 3, 3, C_NOP);

      repeat (2) @(negedge clk);
      // R1 reset state
      chk("R1 pc", int'(pc_o), 0);
      chk("R1 ex_ctl", int'(ex_ctl_o), 0);
      chk("R1 pc_write", int'(pc_write_o), 1);
      chk("R1 ifid_write", int'(ifid_write_o), 1);
      chk("R1 bubble", int'(bubble_o), 0);
      @(posedge clk); #(CLK_T/4);
      rst_n = 1'b1; run = 1'b1;
      repeat (45) @(negedge clk);
      #1;
      chk("R2 stall count rs match", stalls[2], 1);
      chk("R3 stall count rt match", stalls[6], 1);
      chk("R5 stall count independent", stalls[10], 0);
      chk("R11 stall count two slots", stalls[14], 0);
      chk("R4 stall count non-load", stalls[17], 0);
      chk("R9 stall count reg0", stalls[20], 1);
      chk("R8 stall count chained first", stalls[23], 1);
      chk("R8 stall count chained second", stalls[24], 1);
      done = 1;
      summary();
      $finish;
   end
endmodule